// File: doc/BRIEF.md
# Power Domain On/Off Sequencer

This block holds the control state for a small set of on-chip power domains. Each domain has three kinds of control output. The first is a power-switch bit that is set while the domain is switched off. The second is an active-low subsystem reset line. The third is an isolation bit that clamps the domain's outputs while it is cleared.

Software can read and write the power, reset and isolation registers directly over a simple register port. It can also pulse a single reset line with one write.

A request port starts an automatic sequence for one domain. Turning a domain on runs three steps in this order: apply power, release the reset, lift the clamps. Turning it off runs the mirror order: clamp, assert the reset, cut power. Each action is followed by a programmable settle wait. A domain whose reset or isolation mask is zero skips that step, but the power step always runs. While a sequence runs, `busy` is high. A one-cycle `done` pulse marks its end.

The domain-to-bit mapping is fixed by parameters:

| Domain | Power bit | Isolation bit | Reset bit |
|---|---|---|---|
| 0 | 3 | 0 | 16 |
| 1 | 2 | 1 | 18 |
| 2 | 4 | none | none |

Top module: `pwr_domain_seq`

## Requirements
- R1: After reset the power register reads 0 (every domain powered), the reset register reads 0xFFFFFFFF (every line released), the isolation register reads 0xFFFFFFFF (every clamp lifted), the settle register reads SETTLE_INIT (2), and `busy` and `done` are low.
- R2: Register decode:
  - A write to offset 0x10 replaces the power register (bit set = domain off).
  - A write to 0x30 replaces the reset register (bit cleared = held in reset).
  - A write to 0x58 replaces the isolation register (bit cleared = clamped).
  - A write to 0x60 sets the settle count (low CW bits).
  - Reads of these offsets return the stored value. Reads of any other offset, 0x34 included, return 0.
  - The three control registers drive `pwr_off`, `sub_rst_n` and `iso_rel` directly.
- R3: A turn-on request clears the domain's power bits first, then sets its reset bits, then sets its isolation bits. Each action falls on its own clock edge.
- R4: A turn-off request clears the domain's isolation bits first, then clears its reset bits, then sets its power bits.
- R5: Step timing is set by the settle register value S:
  - Consecutive performed actions of one sequence are exactly S+2 cycles apart.
  - After the final performed action, `done` rises S+1 cycles later.
- R6: A step whose mask is zero changes nothing and costs one cycle with no settle wait. For domain 2, turning on ends with `done` S+3 cycles after the power change, and turning off ends with `done` S+1 cycles after it. The reset and isolation outputs do not move.
- R7: Request handling:
  - A request is accepted only while idle, with `req_dom` below NDOM.
  - `busy` is high from the cycle after acceptance until `done`.
  - `done` is a single-cycle pulse.
  - A request made while busy, or one naming a domain at or above NDOM, has no effect.
- R8: A bus write that lands while a sequence runs is applied first. The sequencer's own-domain update is then applied on top in the same cycle, so bits of other domains written by the bus are kept.
- R9: A write to offset 0x34 with the line number in wdata[4:0] drives that reset bit low for exactly one cycle and then high again. No other bit of any register changes.
- R10: With no bus write and no sequence running, all three control registers hold their values. A sequence changes only the bits named in its domain's masks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access select |
| bus_wr | input | 1 | Write strobe, qualified by bus_sel |
| bus_addr | input | AW | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| req_valid | input | 1 | Sequence request strobe |
| req_on | input | 1 | 1 = turn domain on, 0 = turn it off |
| req_dom | input | DW | Domain index of the request |
| busy | output | 1 | A sequence is in progress |
| done | output | 1 | One-cycle pulse when a sequence ends |
| pwr_off | output | 32 | Power register; a set bit switches that domain off |
| sub_rst_n | output | 32 | Reset register; a cleared bit holds that subsystem in reset |
| iso_rel | output | 32 | Isolation register; a cleared bit clamps that domain |

## Verification
The bench times the first change of each control register and checks both the step order and the exact spacing at zero and non-zero settle counts. A sequencer that swapped steps, used the on-order for off, or waited one cycle too few or too many fails those gaps.

Domain 2 checks the skip path. A design that paid a settle wait for a missing step, or touched a zero mask, gets the wrong `done` time or moves a reset or isolation output.

Further checks cover:
- A request during `busy` and an out-of-range domain, which must leave the outputs untouched.
- A bus write landing mid-sequence, where a design that lets one writer win loses either the foreign bits or the domain's own update.
- The reset pulse, which must last one cycle and leave every neighbour alone.

// File: rtl/pwr_domain_seq.sv
module pwr_domain_seq #(
  parameter int NDOM = 3,
  parameter int AW = 8,
  parameter int CW = 8,
  parameter int SETTLE_INIT = 2,
  parameter logic [NDOM*32-1:0] PWR_MASKS = {32'h0000_0010, 32'h0000_0004, 32'h0000_0008},
  parameter logic [NDOM*32-1:0] ISO_MASKS = {32'h0000_0000, 32'h0000_0002, 32'h0000_0001},
  parameter logic [NDOM*32-1:0] RST_MASKS = {32'h0000_0000, 32'h0004_0000, 32'h0001_0000},
  parameter int DW = (NDOM > 1) ? $clog2(NDOM) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_sel,
  input  logic          bus_wr,
  input  logic [AW-1:0] bus_addr,
  input  logic [31:0]   bus_wdata,
  output logic [31:0]   bus_rdata,
  input  logic          req_valid,
  input  logic          req_on,
  input  logic [DW-1:0] req_dom,
  output logic          busy,
  output logic          done,
  output logic [31:0]   pwr_off,
  output logic [31:0]   sub_rst_n,
  output logic [31:0]   iso_rel
);
  localparam logic [AW-1:0] A_PWR   = AW'('h10);
  localparam logic [AW-1:0] A_RST   = AW'('h30);
  localparam logic [AW-1:0] A_PULSE = AW'('h34);
  localparam logic [AW-1:0] A_ISO   = AW'('h58);
  localparam logic [AW-1:0] A_SET   = AW'('h60);

  typedef enum logic [1:0] {S_IDLE, S_ACT, S_HOLD} st_t;

  st_t            st;
  logic [1:0]     step;
  logic           on_q;
  logic [DW-1:0]  dom_q;
  logic [CW-1:0]  cnt, settle;
  logic [31:0]    pwr_q, rst_q, iso_q;
  logic [31:0]    pwr_d, rst_d, iso_d;
  logic [31:0]    m_pwr, m_rst, m_iso, step_mask;
  logic           pend, done_q;
  logic [4:0]     pend_idx;
  logic           wr, wr_pwr, wr_rst, wr_iso, wr_pulse, wr_set;
  logic           act, last_step, accept;

  assign wr       = bus_sel & bus_wr;
  assign wr_pwr   = wr && (bus_addr == A_PWR);
  assign wr_rst   = wr && (bus_addr == A_RST);
  assign wr_iso   = wr && (bus_addr == A_ISO);
  assign wr_pulse = wr && (bus_addr == A_PULSE);
  assign wr_set   = wr && (bus_addr == A_SET);

  assign act       = (st == S_ACT);
  assign last_step = (step == 2'd2);
  assign accept    = (st == S_IDLE) && req_valid && (32'(req_dom) < NDOM);

  always_comb begin
    m_pwr = '0;
    m_rst = '0;
    m_iso = '0;
    for (int i = 0; i < NDOM; i++) begin
      if (32'(dom_q) == i) begin
        m_pwr = PWR_MASKS[i*32 +: 32];
        m_rst = RST_MASKS[i*32 +: 32];
        m_iso = ISO_MASKS[i*32 +: 32];
      end
    end
  end

  assign step_mask = (step == 2'd1) ? m_rst : (((step == 2'd0) == on_q) ? m_pwr : m_iso);

  always_comb begin
    pwr_d = wr_pwr ? bus_wdata : pwr_q;
    rst_d = wr_rst ? bus_wdata : rst_q;
    iso_d = wr_iso ? bus_wdata : iso_q;
    if (pend)     rst_d = rst_d | (32'd1 << pend_idx);
    if (wr_pulse) rst_d = rst_d & ~(32'd1 << bus_wdata[4:0]);
    if (act) begin
      case (step)
        2'd0:    if (on_q) pwr_d = pwr_d & ~m_pwr; else iso_d = iso_d & ~m_iso;
        2'd1:    if (on_q) rst_d = rst_d | m_rst;  else rst_d = rst_d & ~m_rst;
        default: if (on_q) iso_d = iso_d | m_iso;  else pwr_d = pwr_d | m_pwr;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pwr_q    <= '0;
      rst_q    <= '1;
      iso_q    <= '1;
      pend     <= 1'b0;
      pend_idx <= '0;
      settle   <= CW'(SETTLE_INIT);
    end else begin
      pwr_q    <= pwr_d;
      rst_q    <= rst_d;
      iso_q    <= iso_d;
      pend     <= wr_pulse;
      pend_idx <= bus_wdata[4:0];
      if (wr_set) settle <= bus_wdata[CW-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      step   <= '0;
      on_q   <= 1'b0;
      dom_q  <= '0;
      cnt    <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (st)
        S_IDLE: if (accept) begin
          st    <= S_ACT;
          step  <= 2'd0;
          on_q  <= req_on;
          dom_q <= req_dom;
        end
        S_ACT: begin
          if (step_mask != '0) begin
            cnt <= settle;
            st  <= S_HOLD;
          end else if (last_step) begin
            st     <= S_IDLE;
            done_q <= 1'b1;
          end else begin
            step <= step + 2'd1;
          end
        end
        S_HOLD: begin
          if (cnt != '0) begin
            cnt <= cnt - 1'b1;
          end else if (last_step) begin
            st     <= S_IDLE;
            done_q <= 1'b1;
          end else begin
            step <= step + 2'd1;
            st   <= S_ACT;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    case (bus_addr)
      A_PWR:   bus_rdata = pwr_q;
      A_RST:   bus_rdata = rst_q;
      A_ISO:   bus_rdata = iso_q;
      A_SET:   bus_rdata = 32'(settle);
      default: bus_rdata = '0;
    endcase
  end

  assign busy      = (st != S_IDLE);
  assign done      = done_q;
  assign pwr_off   = pwr_q;
  assign sub_rst_n = rst_q;
  assign iso_rel   = iso_q;
endmodule

// File: rtl/pwr_domain_seq_chk.sv
module pwr_domain_seq_chk #(
  parameter int AW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bus_sel,
  input logic          bus_wr,
  input logic [AW-1:0] bus_addr,
  input logic [31:0]   bus_wdata,
  input logic          req_valid,
  input logic          busy,
  input logic          done,
  input logic [31:0]   pwr_off,
  input logic [31:0]   sub_rst_n,
  input logic [31:0]   iso_rel
);
  logic wr, wr_pulse;
  assign wr       = bus_sel & bus_wr;
  assign wr_pulse = wr && (bus_addr == AW'('h34));

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R7
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy); // R7
  AST_BUSY_START: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(req_valid)); // R7
  AST_ONE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !wr && !$past(wr)) |=>
      ($countones({!$stable(pwr_off), !$stable(sub_rst_n), !$stable(iso_rel)}) <= 1)); // R3
  AST_PULSE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    wr_pulse |=> !sub_rst_n[$past(bus_wdata[4:0])]); // R9
  AST_PULSE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    wr_pulse |=> ##1 sub_rst_n[$past(bus_wdata[4:0], 2)]); // R9
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !wr && !$past(wr)) |=>
      ($stable(pwr_off) && $stable(sub_rst_n) && $stable(iso_rel))); // R10
endmodule

bind pwr_domain_seq pwr_domain_seq_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .req_valid(req_valid),
  .busy(busy), .done(done), .pwr_off(pwr_off), .sub_rst_n(sub_rst_n),
  .iso_rel(iso_rel)
);

// File: tb/tb_pwr_domain_seq.sv
`timescale 1ns/1ps
module tb_pwr_domain_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_wr = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        req_valid = 1'b0, req_on = 1'b0;
  logic [1:0]  req_dom = '0;
  logic        busy, done;
  logic [31:0] pwr_off, sub_rst_n, iso_rel;

  always #2.5 clk = ~clk;

  pwr_domain_seq dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .req_valid(req_valid), .req_on(req_on), .req_dom(req_dom),
    .busy(busy), .done(done), .pwr_off(pwr_off), .sub_rst_n(sub_rst_n),
    .iso_rel(iso_rel)
  );

  int n_chk = 0, n_fail = 0;
  int cyc = 0, n_done = 0;
  int t_pwr = -1, t_rst = -1, t_iso = -1, t_done = -1, t_rst_last = -1;
  logic [31:0] p_pwr = '0, p_rst = '0, p_iso = '0;
  logic [31:0] m_pwr, m_rst, m_iso;

  function automatic logic [31:0] pm(int d);
    case (d) 0: return 32'h8; 1: return 32'h4; 2: return 32'h10; default: return 0; endcase
  endfunction
  function automatic logic [31:0] im(int d);
    case (d) 0: return 32'h1; 1: return 32'h2; default: return 0; endcase
  endfunction
  function automatic logic [31:0] rm(int d);
    case (d) 0: return 32'h1 << 16; 1: return 32'h1 << 18; default: return 0; endcase
  endfunction

  always @(negedge clk) begin
    cyc++;
    if (pwr_off !== p_pwr && t_pwr < 0) t_pwr = cyc;
    if (iso_rel !== p_iso && t_iso < 0) t_iso = cyc;
    if (sub_rst_n !== p_rst) begin
      if (t_rst < 0) t_rst = cyc;
      t_rst_last = cyc;
    end
    if (done === 1'b1) begin n_done++; t_done = cyc; end
    p_pwr = pwr_off; p_rst = sub_rst_n; p_iso = iso_rel;
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic clr_marks();
    t_pwr = -1; t_rst = -1; t_iso = -1; t_done = -1; t_rst_last = -1;
  endtask

  task automatic bwrite(logic [7:0] a, logic [31:0] d);
    @(negedge clk); #1;
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); #1;
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic bread(logic [7:0] a, output logic [31:0] d);
    @(negedge clk); #1;
    bus_addr = a;
    #0.5 d = bus_rdata;
  endtask

  task automatic request(logic on, logic [1:0] d);
    @(negedge clk); #1;
    req_valid = 1'b1; req_on = on; req_dom = d;
    @(negedge clk); #1;
    req_valid = 1'b0;
  endtask

  task automatic wait_done(int base);
    for (int i = 0; i < 2000 && n_done == base; i++) @(negedge clk);
    #1;
  endtask

  task automatic model_seq(logic on, int d);
    if (on) begin m_pwr &= ~pm(d); m_rst |= rm(d); m_iso |= im(d); end
    else begin m_iso &= ~im(d); m_rst &= ~rm(d); m_pwr |= pm(d); end
  endtask

  task automatic cmp_regs(string tag);
    logic [31:0] v;
    bread(8'h10, v); chk({tag, " pwr"}, v, m_pwr);
    bread(8'h30, v); chk({tag, " rst"}, v, m_rst);
    bread(8'h58, v); chk({tag, " iso"}, v, m_iso);
  endtask

  task automatic run_seq(logic on, int d, int s, string tag);
    int base;
    bwrite(8'h60, 32'(s));
    clr_marks();
    base = n_done;
    request(on, 2'(d));
    chk({tag, " busy after accept"}, 32'(busy), 1);
    wait_done(base);
    model_seq(on, d);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int base;
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    m_pwr = 32'h0; m_rst = 32'hFFFF_FFFF; m_iso = 32'hFFFF_FFFF;

    // R1 reset state
    chk("R1 pwr_off", pwr_off, 32'h0);
    chk("R1 sub_rst_n", sub_rst_n, 32'hFFFF_FFFF);
    chk("R1 iso_rel", iso_rel, 32'hFFFF_FFFF);
    chk("R1 busy/done", {30'd0, busy, done}, 32'h0);
    bread(8'h60, v); chk("R1 settle", v, 32'd2);

    // R2 decode
    bwrite(8'h10, 32'hA5A5_0000); bread(8'h10, v); chk("R2 pwr readback", v, 32'hA5A5_0000);
    chk("R2 pwr_off port", pwr_off, 32'hA5A5_0000);
    bwrite(8'h30, 32'h1234_5678); chk("R2 rst port", sub_rst_n, 32'h1234_5678);
    bwrite(8'h58, 32'h0F0F_F0F0); bread(8'h58, v); chk("R2 iso readback", v, 32'h0F0F_F0F0);
    bwrite(8'h60, 32'hFFFF_FF07); bread(8'h60, v); chk("R2 settle width", v, 32'h07);
    bwrite(8'h44, 32'hFFFF_FFFF); bread(8'h44, v); chk("R2 unmapped read", v, 32'h0);
    bread(8'h34, v); chk("R2 pulse read", v, 32'h0);
    bwrite(8'h10, m_pwr); bwrite(8'h30, m_rst); bwrite(8'h58, m_iso);
    cmp_regs("R2 restore");

    // R4 + R5: off domain 0, settle 3
    run_seq(1'b0, 0, 3, "R4");
    chk("R4 iso before rst gap", 32'(t_rst - t_iso), 32'd5);
    chk("R4 rst before pwr gap R5", 32'(t_pwr - t_rst), 32'd5);
    chk("R5 done after last", 32'(t_done - t_pwr), 32'd4);
    cmp_regs("R4 final");

    // R3 + R5: on domain 0, settle 0
    run_seq(1'b1, 0, 0, "R3");
    chk("R3 pwr before rst gap R5", 32'(t_rst - t_pwr), 32'd2);
    chk("R3 rst before iso gap", 32'(t_iso - t_rst), 32'd2);
    chk("R5 done after last s0", 32'(t_done - t_iso), 32'd1);
    cmp_regs("R3 final");

    // R6 domain 2 without reset or isolation
    run_seq(1'b0, 2, 1, "R6 off");
    chk("R6 off no rst move", 32'(t_rst), 32'hFFFF_FFFF);
    chk("R6 off no iso move", 32'(t_iso), 32'hFFFF_FFFF);
    chk("R6 off done timing", 32'(t_done - t_pwr), 32'd2);
    run_seq(1'b1, 2, 2, "R6 on");
    chk("R6 on no rst move", 32'(t_rst), 32'hFFFF_FFFF);
    chk("R6 on done timing", 32'(t_done - t_pwr), 32'd5);
    cmp_regs("R6 final");

    // R7 request while busy ignored
    bwrite(8'h60, 32'd3);
    run_seq(1'b0, 0, 3, "R7 prep");
    base = n_done;
    request(1'b1, 2'd0);
    request(1'b0, 2'd1);
    wait_done(base);
    model_seq(1'b1, 0);
    repeat (20) @(negedge clk);
    chk("R7 one done only", 32'(n_done - base), 32'd1);
    cmp_regs("R7 busy request ignored");

    // R7 out-of-range domain ignored
    base = n_done;
    request(1'b0, 2'd3);
    chk("R7 bad domain not busy", 32'(busy), 0);
    repeat (10) @(negedge clk);
    chk("R7 bad domain no done", 32'(n_done - base), 32'd0);
    cmp_regs("R7 bad domain");

    // R9 reset pulse
    clr_marks();
    bwrite(8'h34, 32'd16);
    repeat (3) @(negedge clk);
    chk("R9 pulse width", 32'(t_rst_last - t_rst), 32'd1);
    chk("R9 no pwr move", 32'(t_pwr), 32'hFFFF_FFFF);
    cmp_regs("R9 after pulse");

    // R8 bus writes during a sequence
    bwrite(8'h60, 32'd4);
    base = n_done;
    request(1'b0, 2'd1);
    bwrite(8'h10, (m_pwr ^ 32'h100) | 32'h4);
    bwrite(8'h30, m_rst & ~32'h20 & ~(32'h1 << 18));
    wait_done(base);
    m_pwr = (m_pwr ^ 32'h100) | 32'h4;
    m_rst = m_rst & ~32'h20;
    model_seq(1'b0, 1);
    cmp_regs("R8 merged");

    // R10 random mix
    for (int it = 0; it < 60; it++) begin
      int k = $urandom % 4;
      if (k == 0) begin
        logic [31:0] d = $urandom;
        case ($urandom % 3)
          0: begin bwrite(8'h10, d); m_pwr = d; end
          1: begin bwrite(8'h30, d); m_rst = d; end
          default: begin bwrite(8'h58, d); m_iso = d; end
        endcase
      end else begin
        run_seq(1'($urandom % 2), $urandom % 3, $urandom % 4, "R10 rand");
      end
      cmp_regs("R10 random");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule